// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block gives a processor core four 32-bit event counters for profiling. Each counter has its own control register. That register chooses which strobe from an event vector the counter tallies. It also holds a set of freeze conditions, which can block counting by a local hold bit, by the core's privilege mode (supervisor or user), or by the level of a per-process mark input in either polarity. A counter advances by one only on a cycle when its selected strobe is high and none of its freeze conditions apply.

A global control register can freeze every counter at once and can enable the interrupt output. It can also make the hardware freeze every counter by itself when an armed counter reaches its overflow condition. A counter whose condition is armed signals whenever its most significant bit is set. To sample every N events, software preloads the counter with 0x80000000 minus N and takes the level interrupt. Software then rewrites the counter to clear the condition and clears the global freeze. All registers are read and written through a simple port with separate read and write addresses. Reads are combinational.

Top module: `perf_mon_unit`

## Requirements
- R1: After a synchronous active-low reset, every counter reads 0. Every local control reads 0x0000001F, with all five freeze bits set, the condition disarmed and event select 0. The global control reads 0x00000001, so freeze-all is set and the other bits are clear. The interrupt output is low.
- R2: A counter increments by exactly one at a clock edge when its selected strobe evt_i[sel] is 1 and no freeze condition applies. The event select is local control bits 11:8. A register write to the counter in the same cycle takes priority and loads the written value.
- R3: While local control bit 0 (hold) is 1, the counter keeps its value whatever the strobes do.
- R4: Local control bit 1 blocks counting while sup_i is 1 (supervisor). Local control bit 2 blocks counting while sup_i is 0 (user).
- R5: Local control bit 3 blocks counting while mark_i is 1. Local control bit 4 blocks counting while mark_i is 0. With only bit 3 set, the counter advances only while the mark is clear.
- R6: While global control bit 0 (freeze-all) is 1, no counter changes except by a register write, whatever the local settings are.
- R7: A counter's condition is true when its local control bit 5 (arm) is 1 and its bit 31 is 1. irq_o is a level output. It is high exactly when global control bit 1 (interrupt enable) is 1 and at least one condition is true.
- R8: When global control bit 2 (freeze on condition) is 1 and any condition is true during a cycle, global freeze-all reads 1 after the next edge. This hardware set wins over a register write of 0 to freeze-all in the same cycle.
- R9: With the counter preloaded to 0x80000000 minus N and armed, irq_o rises after the Nth counted event. Writing the counter back to the preload value or to zero drops the condition.
- R10: The register map is as follows. Address 0 is global control, 4 to 7 are counters 0 to 3, and 8 to 11 are local controls 0 to 3. Other addresses read 0 and writes to them change nothing. Unused control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 16 | Event strobes, one per selectable event |
| sup_i | input | 1 | 1 when the core runs in supervisor mode, 0 in user mode |
| mark_i | input | 1 | Process mark bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that every input is a known value, held stable across the sampling edge, and that reset is held low over at least one edge before any check is meaningful. They make no assumption about which addresses are written or how often, so writes to unmapped addresses and writes that race a counter overflow are legal. The stimulus changes inputs only on the falling clock edge and draws event, mode and mark values freely. It also preloads counters close to bit 31, so that the overflow, auto-freeze and write-priority cases all occur within these assumptions.

// File: rtl/pmu_pkg.sv
// pmu_pkg: shared constants for the performance monitor unit.
// Assumes a 4-bit register address space and 32-bit register data.
package pmu_pkg;
    localparam int REG_W       = 32;
    localparam int ADDR_W      = 4;
    localparam int NUM_CTR     = 4;
    localparam int IDX_W       = $clog2(NUM_CTR);

    // Local control field positions
    localparam int LC_HOLD     = 0;
    localparam int LC_NO_SUP   = 1;
    localparam int LC_NO_USR   = 2;
    localparam int LC_NO_MK1   = 3;
    localparam int LC_NO_MK0   = 4;
    localparam int LC_ARM      = 5;
    localparam int LC_SEL      = 8;

    // Global control field positions
    localparam int GC_FRZ      = 0;
    localparam int GC_IEN      = 1;
    localparam int GC_FOC      = 2;

    // Address map bases
    localparam int A_GLOBAL    = 0;
    localparam int A_CNT_BASE  = 4;
    localparam int A_LCTL_BASE = 8;

    typedef enum logic [1:0] {
        RK_GLOBAL,
        RK_COUNTER,
        RK_LOCAL,
        RK_NONE
    } reg_kind_t;

    // Classify a register address into its region.
    function automatic reg_kind_t decode_kind(input logic [ADDR_W-1:0] a);
        if (int'(a) == A_GLOBAL)
            return RK_GLOBAL;
        else if (int'(a) >= A_CNT_BASE && int'(a) < A_CNT_BASE + NUM_CTR)
            return RK_COUNTER;
        else if (int'(a) >= A_LCTL_BASE && int'(a) < A_LCTL_BASE + NUM_CTR)
            return RK_LOCAL;
        else
            return RK_NONE;
    endfunction
endpackage

// File: rtl/pmu_counter_slice.sv
// pmu_counter_slice: one event counter with its local control register.
// Counts the selected strobe when no freeze condition applies; a counter
// write wins over an increment. Assumes synchronous inputs and that the
// caller decodes write strobes for this slice.
module pmu_counter_slice
    import pmu_pkg::*;
#(
    parameter int CTR_W   = 32,
    parameter int SEL_W   = 4,
    parameter int NUM_EVT = 1 << SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               sup_i,
    input  logic               mark_i,
    input  logic               frz_all_i,
    input  logic               wr_cnt_i,
    input  logic               wr_ctl_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [REG_W-1:0]   cnt_o,
    output logic [REG_W-1:0]   ctl_o,
    output logic               cond_o
);
    logic             hold_q, no_sup_q, no_usr_q, no_mk1_q, no_mk0_q, arm_q;
    logic [SEL_W-1:0] sel_q;
    logic [CTR_W-1:0] cnt_q;
    logic             blocked;
    logic             count_en;

    // Local control register: reset freezes everything, software loads fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= 1'b1;
            no_sup_q <= 1'b1;
            no_usr_q <= 1'b1;
            no_mk1_q <= 1'b1;
            no_mk0_q <= 1'b1;
            arm_q    <= 1'b0;
            sel_q    <= '0;
        end else if (wr_ctl_i) begin
            hold_q   <= wdata_i[LC_HOLD];
            no_sup_q <= wdata_i[LC_NO_SUP];
            no_usr_q <= wdata_i[LC_NO_USR];
            no_mk1_q <= wdata_i[LC_NO_MK1];
            no_mk0_q <= wdata_i[LC_NO_MK0];
            arm_q    <= wdata_i[LC_ARM];
            sel_q    <= wdata_i[LC_SEL +: SEL_W];
        end
    end

    // Combine every freeze source into one block term.
    always_comb begin
        blocked = hold_q | frz_all_i
                | (sup_i  & no_sup_q) | (~sup_i  & no_usr_q)
                | (mark_i & no_mk1_q) | (~mark_i & no_mk0_q);
        count_en = evt_i[sel_q] & ~blocked;
    end

    // Counter: write has priority, else increment on an enabled event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wr_cnt_i)
            cnt_q <= wdata_i[CTR_W-1:0];
        else if (count_en)
            cnt_q <= cnt_q + 1'b1;
    end

    // Readback and condition outputs.
    always_comb begin
        ctl_o                    = '0;
        ctl_o[LC_HOLD]           = hold_q;
        ctl_o[LC_NO_SUP]         = no_sup_q;
        ctl_o[LC_NO_USR]         = no_usr_q;
        ctl_o[LC_NO_MK1]         = no_mk1_q;
        ctl_o[LC_NO_MK0]         = no_mk0_q;
        ctl_o[LC_ARM]            = arm_q;
        ctl_o[LC_SEL +: SEL_W]   = sel_q;
        cnt_o                    = REG_W'(cnt_q);
        cond_o                   = arm_q & cnt_q[CTR_W-1];
    end

    a_r2_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_i |=> cnt_q == $past(wdata_i[CTR_W-1:0]));
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cnt_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
    a_r3_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !wr_cnt_i) |=> $stable(cnt_q));
    a_r6_freeze_all_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_all_i && !wr_cnt_i) |=> $stable(cnt_q));
    a_r4_sup_block: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_i && no_sup_q && !wr_cnt_i) |=> $stable(cnt_q));
    a_r5_mark_block: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_i && no_mk1_q && !wr_cnt_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pmu_global_ctrl.sv
// pmu_global_ctrl: global freeze-all, interrupt enable and freeze-on-condition.
// Hardware sets freeze-all when enabled and any condition is true; that set
// wins over a same-cycle software write. Assumes cond_any_i is registered-based.
module pmu_global_ctrl
    import pmu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             cond_any_i,
    output logic             frz_all_o,
    output logic             ien_o,
    output logic [REG_W-1:0] reg_o
);
    logic frz_q, ien_q, foc_q;
    logic frz_next;

    // Next freeze-all: software value ORed with the hardware auto-freeze.
    always_comb begin
        frz_next = wr_i ? wdata_i[GC_FRZ] : frz_q;
        if (foc_q && cond_any_i)
            frz_next = 1'b1;
    end

    // Global control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frz_q <= 1'b1;
            ien_q <= 1'b0;
            foc_q <= 1'b0;
        end else begin
            frz_q <= frz_next;
            if (wr_i) begin
                ien_q <= wdata_i[GC_IEN];
                foc_q <= wdata_i[GC_FOC];
            end
        end
    end

    // Readback.
    always_comb begin
        reg_o         = '0;
        reg_o[GC_FRZ] = frz_q;
        reg_o[GC_IEN] = ien_q;
        reg_o[GC_FOC] = foc_q;
        frz_all_o     = frz_q;
        ien_o         = ien_q;
    end

    a_r8_auto_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (foc_q && cond_any_i) |=> frz_q);
    a_r6_freeze_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_q && !wr_i) |=> frz_q);
endmodule

// File: rtl/pmu_read_mux.sv
// pmu_read_mux: combinational register readback selected by address.
// Unmapped addresses return zero. Assumes flat per-counter buses.
module pmu_read_mux
    import pmu_pkg::*;
(
    input  logic [ADDR_W-1:0]        rd_addr_i,
    input  logic [REG_W-1:0]         gctl_i,
    input  logic [NUM_CTR*REG_W-1:0] cnt_flat_i,
    input  logic [NUM_CTR*REG_W-1:0] ctl_flat_i,
    output logic [REG_W-1:0]         rd_data_o
);
    logic [IDX_W-1:0] idx;

    // Select the register addressed by rd_addr_i.
    always_comb begin
        idx = rd_addr_i[IDX_W-1:0];
        unique case (decode_kind(rd_addr_i))
            RK_GLOBAL:  rd_data_o = gctl_i;
            RK_COUNTER: rd_data_o = cnt_flat_i[idx*REG_W +: REG_W];
            RK_LOCAL:   rd_data_o = ctl_flat_i[idx*REG_W +: REG_W];
            default:    rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/perf_mon_unit.sv
// perf_mon_unit: four event counters with local and global freeze control
// and a level overflow interrupt. Assumes synchronous inputs; reads are
// combinational, writes take effect at the next edge.
module perf_mon_unit
    import pmu_pkg::*;
#(
    parameter int CTR_W = 32,
    parameter int SEL_W = 4,
    localparam int NUM_EVT = 1 << SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               sup_i,
    input  logic               mark_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [REG_W-1:0]   wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [REG_W-1:0]   rd_data_o,
    output logic               irq_o
);
    logic [NUM_CTR-1:0]       cond;
    logic [NUM_CTR*REG_W-1:0] cnt_flat;
    logic [NUM_CTR*REG_W-1:0] ctl_flat;
    logic [REG_W-1:0]         gctl;
    logic                     frz_all, ien, cond_any, wr_glob;

    // Global write strobe decode.
    always_comb wr_glob = wr_en_i && (decode_kind(wr_addr_i) == RK_GLOBAL);

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        logic wr_cnt, wr_ctl;
        // Per-slice write strobe decode.
        always_comb begin
            wr_cnt = wr_en_i && (wr_addr_i == ADDR_W'(A_CNT_BASE + g));
            wr_ctl = wr_en_i && (wr_addr_i == ADDR_W'(A_LCTL_BASE + g));
        end
        pmu_counter_slice #(
            .CTR_W   (CTR_W),
            .SEL_W   (SEL_W),
            .NUM_EVT (NUM_EVT)
        ) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt_i),
            .sup_i     (sup_i),
            .mark_i    (mark_i),
            .frz_all_i (frz_all),
            .wr_cnt_i  (wr_cnt),
            .wr_ctl_i  (wr_ctl),
            .wdata_i   (wr_data_i),
            .cnt_o     (cnt_flat[g*REG_W +: REG_W]),
            .ctl_o     (ctl_flat[g*REG_W +: REG_W]),
            .cond_o    (cond[g])
        );
    end

    // Any armed condition.
    always_comb cond_any = |cond;

    pmu_global_ctrl u_glob (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_glob),
        .wdata_i    (wr_data_i),
        .cond_any_i (cond_any),
        .frz_all_o  (frz_all),
        .ien_o      (ien),
        .reg_o      (gctl)
    );

    pmu_read_mux u_rd (
        .rd_addr_i  (rd_addr_i),
        .gctl_i     (gctl),
        .cnt_flat_i (cnt_flat),
        .ctl_flat_i (ctl_flat),
        .rd_data_o  (rd_data_o)
    );

    // Level interrupt.
    always_comb irq_o = ien & cond_any;

    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> gctl[GC_IEN]);
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (decode_kind(rd_addr_i) == RK_NONE) |-> (rd_data_o == '0));
endmodule

// File: tb/perf_mon_unit_tb_top.sv
`timescale 1ns/1ps
module perf_mon_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] evt;
    logic        sup, mark, wr_en;
    logic [3:0]  wr_addr, rd_addr;
    logic [31:0] wr_data, rd_data;
    logic        irq;

    always #5 clk = ~clk;

    perf_mon_unit dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .sup_i(sup), .mark_i(mark),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
    );

    // Behavioural reference state
    logic [31:0] m_cnt [4];
    logic [31:0] m_lc  [4];
    logic [2:0]  m_g;
    int          n_chk = 0;
    int          n_err = 0;
    string       tag = "R1";
    logic [3:0]  ra = 4'd0;

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        int ai = int'(a);
        if (ai == 0) return {29'd0, m_g};
        if (ai >= 4 && ai < 8) return m_cnt[ai-4];
        if (ai >= 8 && ai < 12) return m_lc[ai-8];
        return 32'd0;
    endfunction

    function automatic logic exp_irq();
        logic any = 1'b0;
        for (int i = 0; i < 4; i++)
            if (m_lc[i][5] && m_cnt[i][31]) any = 1'b1;
        return m_g[1] && any;
    endfunction

    task automatic check_now();
        logic [31:0] er = exp_read(rd_addr);
        logic        ei = exp_irq();
        n_chk += 2;
        if (rd_data !== er) begin
            n_err++;
            $display("FAIL %s read addr %0d: actual=%h expected=%h", tag, rd_addr, rd_data, er);
        end
        if (irq !== ei) begin
            n_err++;
            $display("FAIL R7 (%s) irq: actual=%b expected=%b", tag, irq, ei);
        end
    endtask

    task automatic model_step(input logic we, input logic [3:0] wa, input logic [31:0] wd,
                              input logic [15:0] ev, input logic sp, input logic mk);
        logic [31:0] nc [4];
        logic [31:0] nl [4];
        logic [2:0]  ng;
        logic        any = 1'b0;
        for (int i = 0; i < 4; i++)
            if (m_lc[i][5] && m_cnt[i][31]) any = 1'b1;
        for (int i = 0; i < 4; i++) begin
            logic ce;
            ce = ev[m_lc[i][11:8]] && !m_lc[i][0] && !m_g[0]
               && !(sp && m_lc[i][1]) && !(!sp && m_lc[i][2])
               && !(mk && m_lc[i][3]) && !(!mk && m_lc[i][4]);
            if (we && int'(wa) == 4 + i) nc[i] = wd;
            else if (ce)                 nc[i] = m_cnt[i] + 32'd1;
            else                         nc[i] = m_cnt[i];
            nl[i] = (we && int'(wa) == 8 + i) ? (wd & 32'h0000_0F3F) : m_lc[i];
        end
        ng = (we && wa == 4'd0) ? wd[2:0] : m_g;
        if (m_g[2] && any) ng[0] = 1'b1;
        for (int i = 0; i < 4; i++) begin
            m_cnt[i] = nc[i];
            m_lc[i]  = nl[i];
        end
        m_g = ng;
    endtask

    task automatic cyc(input logic we, input logic [3:0] wa, input logic [31:0] wd,
                       input logic [15:0] ev, input logic sp, input logic mk);
        @(negedge clk);
        check_now();
        wr_en = we; wr_addr = wa; wr_data = wd;
        evt = ev; sup = sp; mark = mk;
        rd_addr = ra;
        ra = ra + 4'd1;
        model_step(we, wa, wd, ev, sp, mk);
    endtask

    task automatic run_free(input int n);
        for (int k = 0; k < n; k++)
            cyc(1'b0, 4'd0, 32'd0, 16'($urandom), 1'($urandom), 1'($urandom));
    endtask

    task automatic wreg(input logic [3:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 16'($urandom), 1'($urandom), 1'($urandom));
    endtask

    task automatic run_all_events(input int n);
        for (int k = 0; k < n; k++)
            cyc(1'b0, 4'd0, 32'd0, 16'hFFFF, 1'($urandom), 1'($urandom));
    endtask

    // Watchdog
    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; evt = '0; sup = 1'b0; mark = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        for (int i = 0; i < 4; i++) begin
            m_cnt[i] = 32'd0;
            m_lc[i]  = 32'h0000_001F;
        end
        m_g = 3'b001;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values, frozen counters under random strobes
        tag = "R1";
        run_free(16);

        // R10: unmapped writes ignored, unused control bits read zero
        tag = "R10";
        wreg(4'd2, 32'hFFFF_FFFF);
        wreg(4'd13, 32'hFFFF_FFFF);
        wreg(4'd9, 32'hFFFF_FFFF);
        run_free(16);

        // R2: counting on selected events, no freeze
        tag = "R2";
        for (int i = 0; i < 4; i++) wreg(4'(8 + i), 32'(i) << 8);
        wreg(4'd0, 32'd0);
        run_free(40);
        wreg(4'd5, 32'h0000_1000);
        run_all_events(4);
        wreg(4'd5, 32'h0000_2000);
        run_free(8);

        // R3: local hold on counter 1
        tag = "R3";
        wreg(4'd9, 32'h0000_0101);
        run_all_events(20);

        // R4: privilege freezes
        tag = "R4";
        wreg(4'd8, 32'h0000_0002);
        wreg(4'd10, 32'h0000_0204);
        run_free(40);

        // R5: mark freezes in both polarities
        tag = "R5";
        wreg(4'd8, 32'h0000_0008);
        wreg(4'd11, 32'h0000_0310);
        run_all_events(40);

        // R6: global freeze-all
        tag = "R6";
        wreg(4'd0, 32'd1);
        run_all_events(20);
        wreg(4'd0, 32'd0);
        run_all_events(4);

        // R9 / R7: preload for 5 events, level interrupt, clear by rewrite
        tag = "R9";
        wreg(4'd10, 32'h0000_0220);
        wreg(4'd6, 32'h8000_0000 - 32'd5);
        wreg(4'd0, 32'd2);
        for (int k = 0; k < 8; k++) cyc(1'b0, 4'd0, 32'd0, 16'h0004, 1'b0, 1'b0);
        tag = "R7";
        run_free(6);
        wreg(4'd6, 32'd0);
        run_free(4);
        wreg(4'd6, 32'h8000_0000 - 32'd3);
        run_free(4);

        // R8: freeze on condition, hardware set beats a clearing write
        tag = "R8";
        wreg(4'd6, 32'd0);
        wreg(4'd9, 32'h0000_0120);
        wreg(4'd5, 32'h8000_0000 - 32'd3);
        wreg(4'd0, 32'd6);
        run_all_events(8);
        wreg(4'd0, 32'd6);
        run_all_events(3);
        wreg(4'd5, 32'h8000_0000 - 32'd3);
        wreg(4'd0, 32'd6);
        run_all_events(10);

        // Mixed stress across all requirements
        tag = "R2";
        for (int k = 0; k < 2000; k++) begin
            if ($urandom % 4 == 0) begin
                logic [31:0] d = ($urandom % 2) ? (32'h7FFF_FFF8 + 32'($urandom % 8)) : $urandom;
                wreg(4'($urandom), d);
            end else begin
                run_free(1);
            end
        end
        run_free(2);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule